// File: doc/BRIEF.md
# Non-PCM Burst Preamble Detector

This block sits behind a stereo digital audio receiver and inspects the 16-bit audio words taken from the received frame stream. Compressed payloads are carried in bursts that start with a fixed preamble. This block looks for that preamble in the stream of valid words. When it finds a complete preamble it raises a non-PCM flag. That flag can then steer the downstream logic away from treating the samples as linear audio.

After a preamble, the next two valid words are the burst-information word and the length-code word. They are published together on two output registers, and a one-cycle event marks the update. The flag is held as long as bursts keep arriving. A frame-strobe counter clears the flag once a long stretch of frames passes with no new preamble.

All state is in one clock domain with a synchronous active-high reset. A word is consumed only in a cycle where its valid strobe is high.

Top module: `nonpcm_burst_detector`

## Requirements
- R1: A preamble is six valid words in this order: 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F. Cycles with `word_vld` low are skipped and do not break the sequence.
- R2: `npcm_flag` goes high on the clock edge that accepts the 0x4E1F word of a complete preamble.
- R3: `npcm_flag` goes low on the edge that accepts the 4096th `frame_stb` pulse counted from the last preamble, when no preamble arrives in between. Each new preamble restarts that count.
- R4: A zero run longer than four words still leads to a match. Any of the following restarts the search and gives no match: fewer than four zeros before 0xF872, or a word other than 0xF872 after the zeros, or a word other than 0x4E1F after 0xF872. A 0x0000 word seen in place of 0x4E1F counts as the first zero of a new run.
- R5: The first valid word after a matched preamble goes to `pc_word` and the second to `pd_word`. Both outputs change together, on the edge that accepts the second word.
- R6: `burst_evt` is high for exactly one cycle, following the edge that updates `pc_word` and `pd_word`, and is low otherwise.
- R7: `pc_word` and `pd_word` keep their values at all other times, including while a failed or partial sequence is received.
- R8: A synchronous reset clears the following to zero: `npcm_flag`, `pc_word`, `pd_word` and `burst_evt`. It also clears the frame count and any partial match, so a sequence begun before reset cannot complete after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_vld | input | 1 | Strobe: `word_in` holds a received audio word |
| word_in | input | 16 | Received audio word |
| frame_stb | input | 1 | One pulse per received stereo frame |
| npcm_flag | output | 1 | High while a compressed stream is present |
| pc_word | output | 16 | Last burst-information word |
| pd_word | output | 16 | Last length-code word |
| burst_evt | output | 1 | One-cycle pulse when `pc_word`/`pd_word` update |

## Verification
Every result is registered once. The flag rises on the edge that accepts 0x4E1F, and falls on the edge that accepts the 4096th frame strobe. The Pc/Pd outputs and the event change on the edge that accepts the second word after the preamble. The bench drives each word or strobe on a falling edge and holds it through one rising edge. It samples the outputs on the next falling edge, so every check looks at the cycle in which the result is due. The timeout is checked one strobe early, with the flag still high, and again on the exact strobe that clears it. The event is checked once more a cycle later to confirm that it has dropped.

// File: rtl/nonpcm_burst_detector.sv
module nonpcm_burst_detector #(
  parameter int          WORD_W         = 16,
  parameter int          ZERO_RUN       = 4,
  parameter int          TIMEOUT_FRAMES = 4096,
  parameter logic [15:0] SYNC_A         = 16'hF872,
  parameter logic [15:0] SYNC_B         = 16'h4E1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              frame_stb,
  output logic              npcm_flag,
  output logic [WORD_W-1:0] pc_word,
  output logic [WORD_W-1:0] pd_word,
  output logic              burst_evt
);

  localparam int CW = $clog2(TIMEOUT_FRAMES + 1);
  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_FRAMES - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(TIMEOUT_FRAMES);
  localparam logic [ZW-1:0] ZRUN     = ZW'(ZERO_RUN);

  typedef enum logic [1:0] {HUNT, WANT_B, TAKE_PC, TAKE_PD} st_t;

  st_t               st;
  logic [ZW-1:0]     zcnt;
  logic [CW-1:0]     fcnt;
  logic [WORD_W-1:0] pc_hold;

  logic is_zero, is_a, is_b, matched, expire;

  assign is_zero = (word_in == '0);
  assign is_a    = (word_in == WORD_W'(SYNC_A));
  assign is_b    = (word_in == WORD_W'(SYNC_B));
  assign matched = word_vld && (st == WANT_B) && is_b;
  assign expire  = frame_stb && (fcnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= HUNT;
      zcnt      <= '0;
      pc_hold   <= '0;
      pc_word   <= '0;
      pd_word   <= '0;
      burst_evt <= 1'b0;
    end else begin
      burst_evt <= 1'b0;
      if (word_vld) begin
        case (st)
          HUNT: begin
            if (is_zero) begin
              if (zcnt != ZRUN) zcnt <= zcnt + 1'b1;
            end else if (is_a && zcnt == ZRUN) begin
              st   <= WANT_B;
              zcnt <= '0;
            end else begin
              zcnt <= '0;
            end
          end
          WANT_B: begin
            if (is_b) begin
              st   <= TAKE_PC;
              zcnt <= '0;
            end else begin
              st   <= HUNT;
              zcnt <= is_zero ? ZW'(1) : '0;
            end
          end
          TAKE_PC: begin
            pc_hold <= word_in;
            st      <= TAKE_PD;
          end
          default: begin
            pc_word   <= pc_hold;
            pd_word   <= word_in;
            burst_evt <= 1'b1;
            st        <= HUNT;
            zcnt      <= '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt      <= '0;
      npcm_flag <= 1'b0;
    end else if (matched) begin
      fcnt      <= '0;
      npcm_flag <= 1'b1;
    end else begin
      if (frame_stb && fcnt != CNT_SAT) fcnt <= fcnt + 1'b1;
      if (expire) npcm_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/nonpcm_burst_detector_chk.sv
module nonpcm_burst_detector_chk #(
  parameter int          WORD_W = 16,
  parameter logic [15:0] SYNC_B = 16'h4E1F
) (
  input logic              clk,
  input logic              rst,
  input logic              word_vld,
  input logic [WORD_W-1:0] word_in,
  input logic              frame_stb,
  input logic              npcm_flag,
  input logic [WORD_W-1:0] pc_word,
  input logic [WORD_W-1:0] pd_word,
  input logic              burst_evt
);

  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(npcm_flag) |-> $past(word_vld && word_in == WORD_W'(SYNC_B)));

  assert_flag_fall_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(npcm_flag) && !$past(rst)) |-> $past(frame_stb));

  assert_evt_needs_word_R5: assert property (@(posedge clk) disable iff (rst)
    (burst_evt && !$past(rst)) |-> $past(word_vld));

  assert_evt_single_R6: assert property (@(posedge clk) disable iff (rst)
    burst_evt |=> !burst_evt);

  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!burst_evt && !$past(rst)) |-> $stable(pc_word));

  assert_pd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!burst_evt && !$past(rst)) |-> $stable(pd_word));

  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) |-> (!npcm_flag && !burst_evt && pc_word == '0 && pd_word == '0));

endmodule

bind nonpcm_burst_detector nonpcm_burst_detector_chk #(
  .WORD_W(WORD_W), .SYNC_B(SYNC_B)
) u_chk (
  .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
  .frame_stb(frame_stb), .npcm_flag(npcm_flag), .pc_word(pc_word),
  .pd_word(pd_word), .burst_evt(burst_evt)
);

// File: tb/tb_nonpcm_burst_detector.sv
module tb_nonpcm_burst_detector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [15:0] word_in = '0;
  logic        frame_stb = 1'b0;
  logic        npcm_flag, burst_evt;
  logic [15:0] pc_word, pd_word;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  nonpcm_burst_detector dut (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .frame_stb(frame_stb), .npcm_flag(npcm_flag), .pc_word(pc_word),
    .pd_word(pd_word), .burst_evt(burst_evt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    word_vld = 1'b1; word_in = w;
    @(negedge clk);
    word_vld = 1'b0; word_in = 16'hDEAD;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
    end
  endtask

  task automatic preamble();
    for (int i = 0; i < 4; i++) put(16'h0000);
    put(16'hF872);
    put(16'h4E1F);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(!npcm_flag, "R8 flag", npcm_flag, 0);
    chk(pc_word == 0 && pd_word == 0, "R8 pc/pd", {pc_word, pd_word}, 0);
    chk(!burst_evt, "R8 evt", burst_evt, 0);
  endtask

  task automatic t_mismatch();
    put(0); put(0); put(0); put(16'hF872); put(16'h4E1F);
    chk(!npcm_flag, "R4 three zeros", npcm_flag, 0);
    preamble_broken_b();
    chk(!npcm_flag, "R4 bad second sync", npcm_flag, 0);
    put(0); put(0); put(0); put(0); put(16'h5555); put(16'hF872); put(16'h4E1F);
    chk(!npcm_flag, "R4 foreign word", npcm_flag, 0);
    put(16'h1111); put(16'h2222);
    chk(pc_word == 0 && pd_word == 0 && !burst_evt, "R7 no capture on mismatch",
        {pc_word, pd_word}, 0);
  endtask

  task automatic preamble_broken_b();
    for (int i = 0; i < 4; i++) put(16'h0000);
    put(16'hF872);
    put(16'h1234);
    put(16'h4E1F);
  endtask

  task automatic t_zero_in_b_slot();
    for (int i = 0; i < 4; i++) put(16'h0000);
    put(16'hF872);
    put(16'h0000);
    put(0); put(0); put(0);
    put(16'hF872);
    put(16'h4E1F);
    chk(npcm_flag, "R4 zero restarts run", npcm_flag, 1);
    put(16'h0101); put(16'h0202);
    chk(pc_word == 16'h0101 && pd_word == 16'h0202, "R5 capture after restart",
        {pc_word, pd_word}, 32'h01010202);
    do_reset();
  endtask

  task automatic t_basic_capture();
    for (int i = 0; i < 4; i++) begin put(16'h0000); idle(2); end
    put(16'hF872); idle(1);
    put(16'h4E1F);
    chk(npcm_flag, "R2 flag on sync B", npcm_flag, 1);
    chk(npcm_flag, "R1 gaps tolerated", npcm_flag, 1);
    put(16'h0015);
    chk(pc_word == 0 && !burst_evt, "R5 pc not yet published", pc_word, 0);
    idle(1);
    put(16'h1800);
    chk(pc_word == 16'h0015 && pd_word == 16'h1800, "R5 pc/pd",
        {pc_word, pd_word}, 32'h00151800);
    chk(burst_evt, "R6 evt high", burst_evt, 1);
    @(negedge clk);
    chk(!burst_evt, "R6 evt one cycle", burst_evt, 0);
    put(16'h7777); put(0); put(0); put(16'h9999);
    chk(pc_word == 16'h0015 && pd_word == 16'h1800, "R7 hold",
        {pc_word, pd_word}, 32'h00151800);
  endtask

  task automatic t_long_zero_run();
    for (int i = 0; i < 9; i++) put(16'h0000);
    put(16'hF872); put(16'h4E1F);
    chk(npcm_flag, "R4 long zero run", npcm_flag, 1);
    put(16'h0003); put(16'h2000);
    chk(pc_word == 16'h0003 && pd_word == 16'h2000 && burst_evt, "R5 second burst",
        {pc_word, pd_word}, 32'h00032000);
  endtask

  task automatic t_timeout();
    frames(4095);
    chk(npcm_flag, "R3 held at 4095", npcm_flag, 1);
    preamble();
    put(16'h0001); put(16'h0002);
    frames(4095);
    chk(npcm_flag, "R3 restarted count", npcm_flag, 1);
    frames(1);
    chk(!npcm_flag, "R3 cleared at 4096", npcm_flag, 0);
    frames(300);
    chk(!npcm_flag, "R3 stays clear", npcm_flag, 0);
    chk(pc_word == 16'h0001 && pd_word == 16'h0002, "R7 hold after timeout",
        {pc_word, pd_word}, 32'h00010002);
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < 4; i++) put(16'h0000);
    put(16'hF872);
    do_reset();
    put(16'h4E1F);
    chk(!npcm_flag, "R8 partial match dropped", npcm_flag, 0);
    chk(pc_word == 0 && pd_word == 0, "R8 pc/pd cleared", {pc_word, pd_word}, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    t_reset_state();
    t_mismatch();
    t_zero_in_b_slot();
    t_basic_capture();
    t_long_zero_run();
    t_timeout();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule